// File: doc/BRIEF.md
# Bit-6 Address Swizzler for Dual-Channel Interleaved Memory

This block sits on a byte-address path in front of a two-channel memory. Both channels are interleaved on address bit 6, so the address must match the channel pattern that the tiled-surface reader expects. The block rewrites bit 6 of each address. It XORs into bit 6 a set of higher address bits, and that set depends on two things: the surface tiling (linear, X-tiled or Y-tiled) and how the memory is organised. Every other address bit passes through unchanged.

Configuration comes in on four inputs:
- a requested tiling code;
- a memory-organisation word, whose low three bits select the organisation;
- two channel population sizes, used only by the size-compare organisation.

From these the block derives an internal fold code and keeps it in a mode register. The mode register is reloaded only when no address is held in the pipeline. During a reload the input is stalled.

The block also reports a mode code and the effective tiling. In the reported mode, any bit-17 term is removed, but the address path still applies it. An organisation word that reads as all ones marks the configuration as unknown. An unknown configuration forces linear treatment, with no fold applied.

The controller has three states:
- LOAD: the mode register captures the decoded configuration. The input is not ready. The next state is always EMPTY.
- EMPTY: the pipeline holds nothing. If the decoded configuration differs from the register (STALE), the next state is LOAD. Otherwise the input is ready, and an accepted address moves the controller to FULL.
- FULL: one result is held on the output.
  - If the consumer takes it and the configuration is not STALE, a new address may be accepted in the same cycle. The controller then stays in FULL if one arrives, or goes to EMPTY if none does.
  - If the consumer takes it and the configuration is STALE, the controller goes to EMPTY.
  - If the consumer does not take it, the controller stays in FULL.

Reset enters LOAD.

Top module: `bit6_swizzler`

## Requirements
- R1: Every output address bit other than bit 6 equals the same bit of the accepted input address.
- R2: Tiling code is 0 linear, 1 X, 2 Y, and 3 is treated as linear. Organisation field org = cfg_word[2:0]. With org 2 (interleaved, channel XOR off), X folds bits 9 and 10 into bit 6 and reports mode 2. Y folds bit 9 only and reports mode 1.
- R3: With org 3 (channel XOR on bit 11), X folds bits 9, 10 and 11 and reports mode 4. Y folds bits 9 and 11 and reports mode 3.
- R4: With org 4 (channel XOR on bit 17), X folds bits 9, 10 and 17 but reports mode 2. Y folds bits 9 and 17 but reports mode 1. A reported mode is never 5, 6 or 7.
- R5: Org 0 (single channel), org 1 (asymmetric dual channel), org 6 and org 7 fold nothing and report mode 0. A linear tiling code folds nothing and reports mode 0 and tile_o 0, whatever the organisation.
- R6: With org 5 (size compare), equal size_a and size_b behave as org 2. Unequal sizes fold nothing and report mode 0.
- R7: A cfg_word of all ones marks the configuration unknown. The address is passed unchanged, mode 0 is reported, and tile_o is 0 even for a tiled request. With a tiled, known configuration, tile_o equals the requested code.
- R8: An address accepted on a clock edge (in_valid and in_ready) appears on out_addr with out_valid one clock later. While out_valid is high and out_ready is low, out_addr holds and in_ready is low. With out_ready high, a new address is accepted in the same cycle the held one leaves.
- R9: swz_mode_o and tile_o change only in a cycle after which no result is pending. A configuration change made while a result is held does not alter that result or the reported mode until the result has left. After the change is loaded, the new configuration applies to later addresses.
- R10: After reset, out_valid is low, the reported mode is 0 and tile_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tile_req | input | 2 | Requested tiling: 0 linear, 1 X, 2 Y, 3 linear |
| cfg_word | input | CFG_W | Memory-organisation word; bits [2:0] select the organisation, all ones means unknown |
| size_a | input | SIZE_W | Populated size of channel A (used by org 5) |
| size_b | input | SIZE_W | Populated size of channel B (used by org 5) |
| in_valid | input | 1 | Input address valid |
| in_addr | input | ADDR_W | Linear byte address |
| in_ready | output | 1 | Block can accept an address |
| out_valid | output | 1 | Translated address valid |
| out_ready | input | 1 | Consumer takes the translated address |
| out_addr | output | ADDR_W | Translated address |
| swz_mode_o | output | 3 | Reported swizzle mode with bit 17 hidden (0 none, 1 bit 9, 2 bits 9+10, 3 bits 9+11, 4 bits 9+10+11) |
| tile_o | output | 2 | Effective tiling after the unknown check |

## Verification
The main sweep covers every tiling code, every organisation value, equal and unequal channel sizes, and the all-ones word. Under each of these configurations it sends all 32 combinations of address bits 6, 9, 10, 11 and 17 over a shifting background pattern.

- Because all tap combinations are sent, a wrong or missing fold bit is visible for each mode on its own.
- The background pattern catches corruption of the pass-through bits.
- Comparing org 3 with org 4 separates folding bit 11 from folding bit 17.
- Comparing reported against applied behaviour under org 4 exposes the bit-17 hiding.

Separate sequences cover three further cases:
- Holding out_ready low checks that the held result stays put and that no new address is taken.
- Releasing out_ready with an input waiting checks back-to-back acceptance.
- Changing the configuration under a held result checks that the mode is reloaded only after the pipeline drains.

// File: rtl/bit6_swz_pkg.sv
package bit6_swz_pkg;

    typedef enum logic [1:0] {
        TILE_NONE = 2'd0,
        TILE_X    = 2'd1,
        TILE_Y    = 2'd2,
        TILE_RSVD = 2'd3
    } tile_e;

    typedef enum logic [2:0] {
        SWZ_NONE     = 3'd0,
        SWZ_9        = 3'd1,
        SWZ_9_10     = 3'd2,
        SWZ_9_11     = 3'd3,
        SWZ_9_10_11  = 3'd4,
        SWZ_9_17     = 3'd5,
        SWZ_9_10_17  = 3'd6,
        SWZ_UNKNOWN  = 3'd7
    } swz_e;

    typedef enum logic [2:0] {
        ORG_SINGLE    = 3'd0,
        ORG_ASYM      = 3'd1,
        ORG_ILV_PLAIN = 3'd2,
        ORG_ILV_B11   = 3'd3,
        ORG_ILV_B17   = 3'd4,
        ORG_BY_SIZE   = 3'd5,
        ORG_RSVD6     = 3'd6,
        ORG_RSVD7     = 3'd7
    } org_e;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_EMPTY = 2'd1,
        ST_FULL  = 2'd2
    } st_e;

    // Address bit positions that can be folded into the channel-select bit.
    localparam int unsigned SEL_BIT = 6;
    localparam int unsigned TAP_NUM = 4;
    localparam int unsigned TAP_POS [TAP_NUM] = '{9, 10, 11, 17};

    // Tap enables for a fold code, in the order of TAP_POS.
    function automatic logic [TAP_NUM-1:0] swz_taps(input swz_e m);
        logic [TAP_NUM-1:0] t;
        case (m)
            SWZ_9:       t = 4'b0001;
            SWZ_9_10:    t = 4'b0011;
            SWZ_9_11:    t = 4'b0101;
            SWZ_9_10_11: t = 4'b0111;
            SWZ_9_17:    t = 4'b1001;
            SWZ_9_10_17: t = 4'b1011;
            default:     t = 4'b0000;
        endcase
        return t;
    endfunction

    // Reported form: bit-17 term removed, unknown shown as none.
    function automatic swz_e swz_report(input swz_e m);
        case (m)
            SWZ_9_17:    return SWZ_9;
            SWZ_9_10_17: return SWZ_9_10;
            SWZ_UNKNOWN: return SWZ_NONE;
            default:     return m;
        endcase
    endfunction

endpackage

// File: rtl/swz_mode_decode.sv
module swz_mode_decode
    import bit6_swz_pkg::*;
#(
    parameter int CFG_W  = 8,
    parameter int SIZE_W = 8
) (
    input  logic [1:0]        tile_req,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [SIZE_W-1:0] size_a,
    input  logic [SIZE_W-1:0] size_b,
    output swz_e              fold_mode,
    output tile_e             eff_tile
);
    logic is_x;
    logic tiled;
    swz_e base_mode;

    assign is_x  = (tile_req == TILE_X);
    assign tiled = (tile_req == TILE_X) || (tile_req == TILE_Y);

    always_comb begin
        base_mode = is_x ? SWZ_9_10 : SWZ_9;
        fold_mode = SWZ_NONE;
        eff_tile  = TILE_NONE;
        if (tiled) begin
            if (&cfg_word) begin
                fold_mode = SWZ_UNKNOWN;
            end else begin
                case (org_e'(cfg_word[2:0]))
                    ORG_ILV_PLAIN: fold_mode = base_mode;
                    ORG_ILV_B11:   fold_mode = is_x ? SWZ_9_10_11 : SWZ_9_11;
                    ORG_ILV_B17:   fold_mode = is_x ? SWZ_9_10_17 : SWZ_9_17;
                    ORG_BY_SIZE:   fold_mode = (size_a == size_b) ? base_mode : SWZ_NONE;
                    default:       fold_mode = SWZ_NONE;
                endcase
            end
            eff_tile = (fold_mode == SWZ_UNKNOWN) ? TILE_NONE : tile_e'(tile_req);
        end
    end
endmodule

// File: rtl/swz_fold.sv
module swz_fold
    import bit6_swz_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  swz_e              mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    logic [TAP_NUM-1:0] en;
    logic [TAP_NUM-1:0] term;

    assign en = swz_taps(mode);

    for (genvar g = 0; g < TAP_NUM; g++) begin : g_tap
        assign term[g] = en[g] & addr_in[TAP_POS[g]];
    end

    always_comb begin
        addr_out          = addr_in;
        addr_out[SEL_BIT] = addr_in[SEL_BIT] ^ (^term);
    end
endmodule

// File: rtl/bit6_swizzler.sv
module bit6_swizzler
    import bit6_swz_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CFG_W  = 8,
    parameter int SIZE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        tile_req,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [SIZE_W-1:0] size_a,
    input  logic [SIZE_W-1:0] size_b,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [2:0]        swz_mode_o,
    output logic [1:0]        tile_o
);
    st_e   state_q, state_d;
    swz_e  mode_d, mode_q;
    tile_e tile_d, tile_q;
    logic  stale;
    logic  load_en;
    logic  take;
    logic [ADDR_W-1:0] folded;

    swz_mode_decode #(.CFG_W(CFG_W), .SIZE_W(SIZE_W)) u_dec (
        .tile_req  (tile_req),
        .cfg_word  (cfg_word),
        .size_a    (size_a),
        .size_b    (size_b),
        .fold_mode (mode_d),
        .eff_tile  (tile_d)
    );

    swz_fold #(.ADDR_W(ADDR_W)) u_fold (
        .mode     (mode_q),
        .addr_in  (in_addr),
        .addr_out (folded)
    );

    assign stale = (mode_d != mode_q) || (tile_d != tile_q);
    assign take  = in_valid && in_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    // Next state and control outputs
    always_comb begin
        state_d  = state_q;
        in_ready = 1'b0;
        load_en  = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                load_en = 1'b1;
                state_d = ST_EMPTY;
            end
            ST_EMPTY: begin
                if (stale) begin
                    state_d = ST_LOAD;
                end else begin
                    in_ready = 1'b1;
                    if (in_valid) state_d = ST_FULL;
                end
            end
            ST_FULL: begin
                if (out_ready) begin
                    if (stale) begin
                        state_d = ST_EMPTY;
                    end else begin
                        in_ready = 1'b1;
                        state_d  = in_valid ? ST_FULL : ST_EMPTY;
                    end
                end
            end
            default: state_d = ST_LOAD;
        endcase
    end

    // Mode register and address register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= SWZ_NONE;
            tile_q   <= TILE_NONE;
            out_addr <= '0;
        end else begin
            if (load_en) begin
                mode_q <= mode_d;
                tile_q <= tile_d;
            end
            if (take) out_addr <= folded;
        end
    end

    assign out_valid  = (state_q == ST_FULL);
    assign swz_mode_o = swz_report(mode_q);
    assign tile_o     = tile_q;

endmodule

// File: rtl/bit6_swizzler_chk.sv
module bit6_swizzler_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic [2:0]        swz_mode_o,
    input logic [1:0]        tile_o
);
    AST_PASS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_addr[ADDR_W-1:7] == $past(in_addr[ADDR_W-1:7]))
                                   && (out_addr[5:0] == $past(in_addr[5:0]))); // R1

    AST_HIDE_B17: assert property (@(posedge clk) disable iff (!rst_n)
        swz_mode_o <= 3'd4); // R4

    AST_LINEAR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && tile_o == 2'd0) |=> (out_addr == $past(in_addr))); // R7

    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr))); // R8

    AST_NO_TAKE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R8

    AST_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> ($stable(swz_mode_o) && $stable(tile_o))); // R9
endmodule

bind bit6_swizzler bit6_swizzler_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_addr    (in_addr),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_addr   (out_addr),
    .swz_mode_o (swz_mode_o),
    .tile_o     (tile_o)
);

// File: tb/bit6_swizzler_bench.sv
module bit6_swizzler_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    tile_req = 2'd0;
    logic [7:0]    cfg_word = 8'h00;
    logic [7:0]    size_a = 8'h40;
    logic [7:0]    size_b = 8'h40;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic          in_ready;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [AW-1:0] out_addr;
    logic [2:0]    swz_mode_o;
    logic [1:0]    tile_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    bit6_swizzler u_bit6_swizzler (
        .clk(clk), .rst_n(rst_n), .tile_req(tile_req), .cfg_word(cfg_word),
        .size_a(size_a), .size_b(size_b), .in_valid(in_valid), .in_addr(in_addr),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .swz_mode_o(swz_mode_o), .tile_o(tile_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Set of address bits folded into bit 6 for a configuration.
    function automatic logic [31:0] fold_mask(input logic [1:0] t, input logic [7:0] c, input bit eq);
        logic [31:0] m;
        if (t == 2'd0 || t == 2'd3 || c == 8'hFF) return 32'h0;
        m = (t == 2'd1) ? ((32'h1 << 9) | (32'h1 << 10)) : (32'h1 << 9);
        case (c[2:0])
            3'd2: return m;
            3'd3: return m | (32'h1 << 11);
            3'd4: return m | (32'h1 << 17);
            3'd5: return eq ? m : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] msk, input logic [31:0] a);
        logic [31:0] r;
        r = a;
        r[6] = a[6] ^ (^(a & msk));
        return r;
    endfunction

    function automatic logic [2:0] exp_mode(input logic [31:0] msk);
        case (msk & ~(32'h1 << 17))
            (32'h1 << 9):                                return 3'd1;
            (32'h1 << 9) | (32'h1 << 10):                return 3'd2;
            (32'h1 << 9) | (32'h1 << 11):                return 3'd3;
            (32'h1 << 9) | (32'h1 << 10) | (32'h1 << 11): return 3'd4;
            default:                                     return 3'd0;
        endcase
    endfunction

    function automatic logic [1:0] exp_tile(input logic [1:0] t, input logic [7:0] c);
        return ((t == 2'd1 || t == 2'd2) && c != 8'hFF) ? t : 2'd0;
    endfunction

    function automatic string req_of(input logic [1:0] t, input logic [7:0] c);
        if (c == 8'hFF) return "R7";
        if (t == 2'd0 || t == 2'd3) return "R5";
        case (c[2:0])
            3'd2: return "R2";
            3'd3: return "R3";
            3'd4: return "R4";
            3'd5: return "R6";
            default: return "R5";
        endcase
    endfunction

    function automatic logic [31:0] pattern(input int k, input int bg);
        logic [31:0] a;
        a = (32'h5A3C_9E21 ^ (bg * 32'h0101_3579)) & ~32'h0002_0E40;
        a[6]  = k[0];
        a[9]  = k[1];
        a[10] = k[2];
        a[11] = k[3];
        a[17] = k[4];
        return a;
    endfunction

    // Drive one address, wait for acceptance, then sit one half-cycle after the edge.
    task automatic send(input logic [31:0] a);
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = a;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] t, input logic [7:0] c, input bit eq);
        @(negedge clk);
        tile_req = t;
        cfg_word = c;
        size_a   = 8'h40;
        size_b   = eq ? 8'h40 : 8'h20;
        repeat (4) @(negedge clk);
    endtask

    task automatic sweep(input logic [1:0] t, input logic [7:0] c, input bit eq);
        logic [31:0] msk;
        string r;
        msk = fold_mask(t, c, eq);
        r = req_of(t, c);
        set_cfg(t, c, eq);
        chk(swz_mode_o == exp_mode(msk), {r, " mode"}, 32'(swz_mode_o), 32'(exp_mode(msk)));
        chk(tile_o == exp_tile(t, c), {r, " tile (R7)"}, 32'(tile_o), 32'(exp_tile(t, c)));
        for (int k = 0; k < 32; k++) begin
            logic [31:0] a;
            a = pattern(k, k + int'(c[2:0]) * 7);
            send(a);
            chk(out_valid == 1'b1, "R8 valid after one clock", 32'(out_valid), 32'h1);
            chk(out_addr == exp_addr(msk, a), {r, " addr (R1)"}, out_addr, exp_addr(msk, a));
        end
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] a1, a2, ma, mb;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10 out_valid in reset", 32'(out_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 out_valid after reset", 32'(out_valid), 32'h0);
        chk(swz_mode_o == 3'd0, "R10 mode after reset", 32'(swz_mode_o), 32'h0);
        chk(tile_o == 2'd0, "R10 tile after reset", 32'(tile_o), 32'h0);

        for (int t = 0; t < 4; t++) begin
            for (int o = 0; o < 8; o++) begin
                for (int e = 0; e < 2; e++) begin
                    sweep(2'(t), {5'b01010, 3'(o)}, e[0]);
                end
            end
            sweep(2'(t), 8'hFF, 1'b1);
        end

        // R8: back-pressure holds the output and blocks input; release takes the next address in the same cycle.
        set_cfg(2'd1, 8'h53, 1'b1);
        ma = fold_mask(2'd1, 8'h53, 1'b1);
        a1 = 32'h0000_0E40;
        a2 = 32'h1234_0A00;
        out_ready = 1'b0;
        send(a1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_addr  = a2;
            #1;
            chk(out_valid == 1'b1, "R8 held valid", 32'(out_valid), 32'h1);
            chk(out_addr == exp_addr(ma, a1), "R8 held addr", out_addr, exp_addr(ma, a1));
            chk(in_ready == 1'b0, "R8 blocked input", 32'(in_ready), 32'h0);
        end
        out_ready = 1'b1;
        #1;
        chk(in_ready == 1'b1, "R8 ready on drain", 32'(in_ready), 32'h1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R8 back-to-back valid", 32'(out_valid), 32'h1);
        chk(out_addr == exp_addr(ma, a2), "R8 back-to-back addr", out_addr, exp_addr(ma, a2));
        @(negedge clk);

        // R9: configuration change under a held result.
        out_ready = 1'b0;
        send(a1);
        @(negedge clk);
        tile_req = 2'd2;
        cfg_word = 8'h54;
        mb = fold_mask(2'd2, 8'h54, 1'b1);
        repeat (3) @(negedge clk);
        chk(swz_mode_o == 3'd4, "R9 mode kept while held", 32'(swz_mode_o), 32'h4);
        chk(tile_o == 2'd1, "R9 tile kept while held", 32'(tile_o), 32'h1);
        chk(out_addr == exp_addr(ma, a1), "R9 held addr kept", out_addr, exp_addr(ma, a1));
        out_ready = 1'b1;
        repeat (4) @(negedge clk);
        chk(swz_mode_o == 3'd1, "R9 new mode loaded (R4 hidden)", 32'(swz_mode_o), 32'h1);
        chk(tile_o == 2'd2, "R9 new tile loaded", 32'(tile_o), 32'h2);
        send(32'h0002_0000);
        chk(out_addr == exp_addr(mb, 32'h0002_0000), "R9 R4 bit17 applied",
            out_addr, exp_addr(mb, 32'h0002_0000));

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule